// File: doc/BRIEF.md
# LED Matrix Column Scanner

The scanner keeps a matrix of LEDs lit with a row-and-column scheme: 5 columns by 7 rows by default. An LED is lit only when its row is driven high and its column sinks current. The block therefore lights the matrix one column at a time. For each column it shifts that column's 7 row bits into an external latched row driver over a serial data / shift clock pair. It then pulses a latch strobe and waits for the driver outputs to settle. Only after that does it enable the single column-select line for a dwell period. It then moves on to the next column, wrapping after the last column, and never stops.

A host fills a frame buffer of one row word per column through a valid/ready write port. A beat transfers on a clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` is low during reset and high from the first clock after reset, so the port never holds the host back in normal operation. A write to an out-of-range column index is accepted and then discarded.

Each scan step copies its column word from the frame buffer when the step begins. Host writes therefore never change a column while it is being shifted or displayed. The shift timing (setup, hold, pulse widths, the clock-to-strobe spacing, the strobe width and the settle time) is given in nanoseconds. Each value becomes a whole number of clock cycles, rounded up from the clock period parameter.

Top module: `led_scan_top`

## Requirements
- R1: While `rst_n` is low, `row_sdata`, `row_sclk`, `row_strobe`, `col_sel` and `wr_ready` are all 0, and the frame buffer is cleared. A write offered during reset is lost.
- R2: `col_sel` has at most one bit set, and it is all zero whenever `row_sclk` or `row_strobe` is high.
- R3: Each step shifts its 7-bit column word with the most significant bit first, one bit per `row_sclk` rising edge. `row_sdata` is 0 outside the shifting phase.
- R4: `row_sdata` is stable for at least ceil(SETUP_NS/CLK_NS) cycles before each `row_sclk` rising edge.
- R5: `row_sclk` stays high for at least ceil(PULSE_NS/CLK_NS) cycles. After each falling edge, `row_sclk` stays low and `row_sdata` stays unchanged for max(ceil(HOLD_NS/CLK_NS), ceil(PULSE_NS/CLK_NS)) cycles.
- R6: `row_strobe` rises only after `row_sclk` has been low for at least ceil(GAP_NS/CLK_NS) cycles.
- R7: `row_strobe` is high for exactly ceil(STB_NS/CLK_NS) cycles.
- R8: After the strobe falls, `col_sel` stays all zero for ceil(SETTLE_NS/CLK_NS) cycles. The step's column is then selected for DWELL_CYC cycles.
- R9: Column index c drives `col_sel[c]`. Columns are visited in the order 0, 1, ..., NCOL-1 and then 0 again. The first step after reset is column 0.
- R10: An accepted write with `wr_col` >= NCOL changes no column's pattern.
- R11: A write to column c takes effect at the next step that displays column c. A step already in progress keeps the word it copied when it began.
- R12: `wr_ready` is 1 on every cycle after the first clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Host offers a frame-buffer write |
| wr_ready | output | 1 | Block accepts the write this cycle |
| wr_col | input | $clog2(NCOL) | Column index written |
| wr_rows | input | NROW | Row pattern for that column, bit r = row r lit |
| row_sdata | output | 1 | Serial row data to the external driver |
| row_sclk | output | 1 | Shift clock to the external driver |
| row_strobe | output | 1 | Latch strobe to the external driver |
| col_sel | output | NCOL | One-hot column sink enable |

## Verification
The checker watches only the four output groups, so its properties assume nothing about the host port. They do assume that `rst_n` is synchronous and that every derived cycle count is at least one. The stimulus writes frame-buffer words at arbitrary moments, including in the middle of the column being shifted, and offers out-of-range column indices. It also presents a write while reset is asserted and drops `wr_valid` before reset is released. It applies a second reset partway through a frame. All inputs change on the falling clock edge, so each write lands on a well-defined rising edge relative to the step boundaries that the reference model tracks.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  typedef enum logic [2:0] {
    PH_LOAD,
    PH_SETUP,
    PH_HIGH,
    PH_HOLD,
    PH_GAP,
    PH_STROBE,
    PH_SETTLE,
    PH_DWELL
  } scan_phase_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/led_scan_fbuf.sv
module led_scan_fbuf #(
  parameter int NCOL = 5,
  parameter int NROW = 7,
  localparam int CW = $clog2(NCOL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CW-1:0]   wr_col,
  input  logic [NROW-1:0] wr_rows,
  input  logic [CW-1:0]   rd_col,
  output logic [NROW-1:0] rd_rows
);

  logic [NROW-1:0] words [NCOL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCOL; c++) words[c] <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < NCOL; c++)
        if (wr_col == CW'(c)) words[c] <= wr_rows;
    end
  end

  always_comb begin
    rd_rows = '0;
    for (int c = 0; c < NCOL; c++)
      if (rd_col == CW'(c)) rd_rows = words[c];
  end

endmodule

// File: rtl/led_scan_timer.sv
module led_scan_timer
  import led_scan_pkg::*;
#(
  parameter int NROW   = 7,
  parameter int SU_C   = 8,
  parameter int PW_C   = 15,
  parameter int HO_C   = 15,
  parameter int GAP_C  = 30,
  parameter int ST_C   = 10,
  parameter int SET_C  = 100,
  parameter int DW_C   = 200,
  localparam int BW    = $clog2(NROW),
  localparam int MAXC  = imax(imax(imax(SU_C, PW_C), imax(HO_C, GAP_C)),
                              imax(imax(ST_C, SET_C), DW_C)),
  localparam int TW    = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output scan_phase_e   phase,
  output logic [BW-1:0] bit_idx,
  output logic          step_done
);

  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_LOAD;
      remain  <= '0;
      bit_idx <= BW'(NROW - 1);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end else begin
      unique case (phase)
        PH_LOAD: begin
          phase   <= PH_SETUP;
          remain  <= TW'(SU_C - 1);
          bit_idx <= BW'(NROW - 1);
        end
        PH_SETUP: begin
          phase  <= PH_HIGH;
          remain <= TW'(PW_C - 1);
        end
        PH_HIGH: begin
          phase  <= PH_HOLD;
          remain <= TW'(HO_C - 1);
        end
        PH_HOLD: begin
          if (bit_idx == '0) begin
            phase  <= PH_GAP;
            remain <= TW'(GAP_C - 1);
          end else begin
            bit_idx <= bit_idx - 1'b1;
            phase   <= PH_SETUP;
            remain  <= TW'(SU_C - 1);
          end
        end
        PH_GAP: begin
          phase  <= PH_STROBE;
          remain <= TW'(ST_C - 1);
        end
        PH_STROBE: begin
          phase  <= PH_SETTLE;
          remain <= TW'(SET_C - 1);
        end
        PH_SETTLE: begin
          phase  <= PH_DWELL;
          remain <= TW'(DW_C - 1);
        end
        default: begin
          phase  <= PH_LOAD;
          remain <= '0;
        end
      endcase
    end
  end

  assign step_done = (phase == PH_DWELL) && (remain == '0);

endmodule

// File: rtl/led_scan_colsel.sv
module led_scan_colsel #(
  parameter int NCOL = 5,
  localparam int CW = $clog2(NCOL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            drive,
  output logic [CW-1:0]   col_idx,
  output logic [NCOL-1:0] col_sel
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      col_idx <= '0;
    else if (advance)
      col_idx <= (col_idx == CW'(NCOL - 1)) ? '0 : col_idx + 1'b1;
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_sink
    assign col_sel[c] = drive && (col_idx == CW'(c));
  end

endmodule

// File: rtl/led_scan_top.sv
module led_scan_top
  import led_scan_pkg::*;
#(
  parameter int NCOL      = 5,
  parameter int NROW      = 7,
  parameter int CLK_NS    = 10,
  parameter int SETUP_NS  = 75,
  parameter int HOLD_NS   = 75,
  parameter int PULSE_NS  = 150,
  parameter int GAP_NS    = 300,
  parameter int STB_NS    = 100,
  parameter int SETTLE_NS = 1000,
  parameter int DWELL_CYC = 200
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [$clog2(NCOL)-1:0] wr_col,
  input  logic [NROW-1:0]         wr_rows,
  output logic                    row_sdata,
  output logic                    row_sclk,
  output logic                    row_strobe,
  output logic [NCOL-1:0]         col_sel
);

  localparam int CW    = $clog2(NCOL);
  localparam int BW    = $clog2(NROW);
  localparam int SU_C  = ns2cyc(SETUP_NS, CLK_NS);
  localparam int PW_C  = ns2cyc(PULSE_NS, CLK_NS);
  localparam int HO_C  = imax(ns2cyc(HOLD_NS, CLK_NS), PW_C);
  localparam int GAP_C = ns2cyc(GAP_NS, CLK_NS);
  localparam int ST_C  = ns2cyc(STB_NS, CLK_NS);
  localparam int SET_C = ns2cyc(SETTLE_NS, CLK_NS);
  localparam int DW_C  = (DWELL_CYC < 1) ? 1 : DWELL_CYC;

  scan_phase_e     phase;
  logic [BW-1:0]   bit_idx;
  logic            step_done;
  logic [CW-1:0]   col_idx;
  logic [NROW-1:0] fb_word;
  logic [NROW-1:0] step_word;
  logic            shifting;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_ready <= 1'b0;
    else        wr_ready <= 1'b1;
  end

  led_scan_fbuf #(.NCOL(NCOL), .NROW(NROW)) u_fbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_valid && wr_ready),
    .wr_col  (wr_col),
    .wr_rows (wr_rows),
    .rd_col  (col_idx),
    .rd_rows (fb_word)
  );

  led_scan_timer #(
    .NROW(NROW), .SU_C(SU_C), .PW_C(PW_C), .HO_C(HO_C),
    .GAP_C(GAP_C), .ST_C(ST_C), .SET_C(SET_C), .DW_C(DW_C)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .bit_idx   (bit_idx),
    .step_done (step_done)
  );

  led_scan_colsel #(.NCOL(NCOL)) u_colsel (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (step_done),
    .drive   (phase == PH_DWELL),
    .col_idx (col_idx),
    .col_sel (col_sel)
  );

  // snapshot of the column word taken once per step
  always_ff @(posedge clk) begin
    if (!rst_n)                 step_word <= '0;
    else if (phase == PH_LOAD)  step_word <= fb_word;
  end

  assign shifting   = (phase == PH_SETUP) || (phase == PH_HIGH) || (phase == PH_HOLD);
  assign row_sdata  = shifting && step_word[bit_idx];
  assign row_sclk   = (phase == PH_HIGH);
  assign row_strobe = (phase == PH_STROBE);

endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk
  import led_scan_pkg::*;
#(
  parameter int NCOL      = 5,
  parameter int CLK_NS    = 10,
  parameter int SETUP_NS  = 75,
  parameter int HOLD_NS   = 75,
  parameter int PULSE_NS  = 150,
  parameter int GAP_NS    = 300,
  parameter int STB_NS    = 100,
  parameter int SETTLE_NS = 1000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            row_sdata,
  input logic            row_sclk,
  input logic            row_strobe,
  input logic [NCOL-1:0] col_sel
);

  localparam int SU_C  = ns2cyc(SETUP_NS, CLK_NS);
  localparam int PW_C  = ns2cyc(PULSE_NS, CLK_NS);
  localparam int HO_C  = imax(ns2cyc(HOLD_NS, CLK_NS), PW_C);
  localparam int GAP_C = ns2cyc(GAP_NS, CLK_NS);
  localparam int ST_C  = ns2cyc(STB_NS, CLK_NS);
  localparam int SET_C = ns2cyc(SETTLE_NS, CLK_NS);

  logic [15:0]     sd_run, hi_run, lo_run, st_run, quiet_run;
  logic            sd_prev;
  logic [NCOL-1:0] last_col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_run    <= '0;
      sd_prev   <= 1'b0;
      hi_run    <= '0;
      lo_run    <= '1;
      st_run    <= '0;
      quiet_run <= '0;
      last_col  <= NCOL'(1) << (NCOL - 1);
    end else begin
      sd_prev <= row_sdata;
      if (row_sdata != sd_prev) sd_run <= 16'd1;
      else if (sd_run != '1)    sd_run <= sd_run + 1'b1;
      hi_run <= row_sclk ? ((hi_run != '1) ? hi_run + 1'b1 : hi_run) : '0;
      lo_run <= row_sclk ? '0 : ((lo_run != '1) ? lo_run + 1'b1 : lo_run);
      st_run <= row_strobe ? st_run + 1'b1 : '0;
      quiet_run <= row_strobe ? '0 : ((quiet_run != '1) ? quiet_run + 1'b1 : quiet_run);
      if (|col_sel) last_col <= col_sel;
    end
  end

  p_col_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_sel));

  p_col_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sclk || row_strobe) |-> (col_sel == '0));

  p_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_sclk) |-> (row_sdata == sd_prev) && (sd_run >= 16'(SU_C)));

  p_clk_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_sclk) |-> (hi_run >= 16'(PW_C)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sdata != sd_prev) |-> (!row_sclk && lo_run >= 16'(HO_C)));

  p_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_sclk) |-> (lo_run >= 16'(HO_C)));

  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_strobe) |-> (!row_sclk && lo_run >= 16'(GAP_C)));

  p_strobe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_strobe) |-> (st_run == 16'(ST_C)));

  p_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|col_sel) |-> (quiet_run >= 16'(SET_C)));

  p_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|col_sel) |-> (col_sel == {last_col[NCOL-2:0], last_col[NCOL-1]}));

endmodule

bind led_scan_top led_scan_chk #(
  .NCOL(NCOL), .CLK_NS(CLK_NS), .SETUP_NS(SETUP_NS), .HOLD_NS(HOLD_NS),
  .PULSE_NS(PULSE_NS), .GAP_NS(GAP_NS), .STB_NS(STB_NS), .SETTLE_NS(SETTLE_NS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .row_sdata  (row_sdata),
  .row_sclk   (row_sclk),
  .row_strobe (row_strobe),
  .col_sel    (col_sel)
);

// File: tb/led_scan_top_tb.sv
`timescale 1ns/1ps
module led_scan_top_tb;

  localparam int NCOL = 5;
  localparam int NROW = 7;
  localparam int TCK  = 10;
  // cycle counts worked out from the requirements, rounded up
  localparam int SU   = (75 + TCK - 1) / TCK;
  localparam int PW   = (150 + TCK - 1) / TCK;
  localparam int HO   = ((75 + TCK - 1) / TCK > PW) ? (75 + TCK - 1) / TCK : PW;
  localparam int GAP  = (300 + TCK - 1) / TCK;
  localparam int STB  = (100 + TCK - 1) / TCK;
  localparam int SETL = (1000 + TCK - 1) / TCK;
  localparam int DWL  = 200;
  localparam int STEP = 1 + NROW * (SU + PW + HO) + GAP + STB + SETL + DWL;
  localparam int FRAME = NCOL * STEP;
  localparam int WD_CYC = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [2:0] wr_col = '0;
  logic [NROW-1:0] wr_rows = '0;
  logic row_sdata, row_sclk, row_strobe;
  logic [NCOL-1:0] col_sel;

  always #5 clk = ~clk;

  led_scan_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_col(wr_col), .wr_rows(wr_rows), .row_sdata(row_sdata),
    .row_sclk(row_sclk), .row_strobe(row_strobe), .col_sel(col_sel)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  logic [NROW-1:0] m_fb [NCOL];
  int exp_q[$];
  int m_next = 0;
  int m_cur = 0;
  bit m_skip_load = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCOL; c++) m_fb[c] <= '0;
    end else if (wr_valid && int'(wr_col) < NCOL) begin
      m_fb[wr_col] <= wr_rows;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, expv, $time);
    end
  endtask

  // encoding of one expected cycle: bit0 sdata, bit1 sclk, bit2 strobe, bits 7:3 columns
  task automatic build_step();
    logic [NROW-1:0] w;
    w = m_fb[m_next];
    if (!m_skip_load) exp_q.push_back(0);
    m_skip_load = 1'b0;
    for (int b = NROW - 1; b >= 0; b--) begin
      for (int i = 0; i < SU; i++) exp_q.push_back(int'(w[b]));
      for (int i = 0; i < PW; i++) exp_q.push_back(2 | int'(w[b]));
      for (int i = 0; i < HO; i++) exp_q.push_back(int'(w[b]));
    end
    for (int i = 0; i < GAP; i++)  exp_q.push_back(0);
    for (int i = 0; i < STB; i++)  exp_q.push_back(4);
    for (int i = 0; i < SETL; i++) exp_q.push_back(0);
    for (int i = 0; i < DWL; i++)  exp_q.push_back((1 << m_next) << 3);
    m_cur = m_next;
    m_next = (m_next + 1) % NCOL;
  endtask

  task automatic tick();
    int e;
    int act;
    @(negedge clk);
    act = (int'(col_sel) << 3) | (int'(row_strobe) << 2) | (int'(row_sclk) << 1) | int'(row_sdata);
    if (!rst_n) begin
      check(act == 0 && wr_ready == 1'b0, "R1 reset outputs", act | (int'(wr_ready) << 8), 0);
      exp_q.delete();
      m_next = 0;
      m_skip_load = 1'b1;
    end else begin
      if (exp_q.size() == 0) build_step();
      e = exp_q.pop_front();
      check(wr_ready == 1'b1, "R12 ready", int'(wr_ready), 1);
      check((act >> 3) == (e >> 3), "R2 R8 R9 R10 R11 column select", act >> 3, e >> 3);
      check(((act >> 2) & 1) == ((e >> 2) & 1), "R6 R7 strobe", (act >> 2) & 1, (e >> 2) & 1);
      check((act & 3) == (e & 3), "R3 R4 R5 shift pins", act & 3, e & 3);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic write_col(input int c, input logic [NROW-1:0] v);
    wr_valid = 1'b1;
    wr_col   = 3'(c);
    wr_rows  = v;
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    int snap;
    // R1: a write offered during reset must be lost
    wr_valid = 1'b1; wr_col = 3'd0; wr_rows = 7'h7F;
    run(3);
    wr_valid = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    snap = n_fail;
    write_col(0, 7'h55);
    write_col(1, 7'h2A);
    write_col(2, 7'h7F);
    write_col(3, 7'h01);
    write_col(4, 7'h40);
    run(2 * FRAME);
    check(n_fail == snap, "R1 R3 R9 first frames", n_fail - snap, 0);

    // R10: out-of-range columns leave the frame untouched
    write_col(5, 7'h7F);
    write_col(6, 7'h00);
    write_col(7, 7'h3C);
    snap = n_fail;
    run(FRAME + STEP);
    check(n_fail == snap, "R10 out-of-range writes", n_fail - snap, 0);

    // R11: rewrite column 2 while it is being shifted
    while (!(m_cur == 2 && exp_q.size() > STEP - 60)) tick();
    write_col(2, 7'h13);
    snap = n_fail;
    run(FRAME + STEP);
    check(n_fail == snap, "R11 no tearing", n_fail - snap, 0);

    // other patterns, written at arbitrary points
    write_col(3, 7'h00);
    run(37);
    write_col(4, 7'h7F);
    run(211);
    write_col(0, 7'h6B);
    run(FRAME);

    // second reset partway through a frame
    rst_n = 1'b0;
    run(3);
    rst_n = 1'b1;
    tick();
    snap = n_fail;
    write_col(1, 7'h5A);
    run(FRAME + STEP);
    check(n_fail == snap, "R1 R9 after second reset", n_fail - snap, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYC);
      summary();
      $finish;
    end
  end

endmodule